// File: doc/BRIEF.md
# Serial Audio Frame CRC Checker

This block checks the integrity of one MPEG-1 Layer I audio frame as it arrives one bit per cycle, most significant bit first. A one-cycle frame-start strobe marks the beginning of a frame. After that, each cycle with the valid input high carries one stream bit. The block follows the frame layout as the bits arrive.

The first sixteen header bits are skipped, apart from their last bit, which says whether a check word is present. The next sixteen header bits go into a CRC-16 register. The sixteen bits after the header are the transmitted check word. They are stored, and they are not fed into the CRC. The bit-allocation field comes next and is also fed into the CRC. The length of that field depends on the channel mode and on the joint-stereo bound, both taken from the header.

When the last protected bit has been taken, the block compares its register with the stored word. It then pulses either a pass output or an error output. A decoder can use the error pulse to mute or repeat the frame.

Top module: `mpa_frame_crc_check`

## Requirements
- R1: The CRC uses generator 0x8005 (x^16+x^15+x^2+1), one bit at a time. On each bit the feedback is the register MSB XOR the data bit. The register shifts left by one, and when the feedback is 1 it is XORed with 0x8005. The register is 16 bits wide.
- R2: A frame_start cycle sets the register to 0xFFFF. The data bit presented in that same cycle is not taken, even when bit_valid is high.
- R3: Frame bits 0 to 15 (sync, ID, layer and the protection bit) are never fed into the CRC. If bit 15, the protection bit, is 1, the frame is not checked and neither flag pulses for it.
- R4: Frame bits 16 to 31 are fed into the CRC in arrival order. In this span, the channel mode is frame bits 24 to 25 and the mode extension is bits 26 to 27, each MSB first.
- R5: Frame bits 32 to 47 form the expected check word, MSB first. They are stored and are not fed into the CRC.
- R6: The allocation field starts at frame bit 48, and its length in bits depends on the channel mode. Mode 11 (one channel) gives 128 bits. Modes 00 and 10 (two channels) give 256 bits. Mode 01 (joint stereo) gives 4*(32+4*(ext+1)) bits, that is 144, 160, 176 or 192.
- R7: When the final CRC equals the stored word, crc_ok is high for exactly the one cycle after the edge that takes the last allocation bit. crc_ok is low at all other times, including after reset.
- R8: When they differ, crc_err pulses at that same cycle instead. crc_ok and crc_err are never high together.
- R9: Cycles with bit_valid low take no bit and do not change the result.
- R10: A frame_start during a frame abandons that frame. No flag pulses for the abandoned frame, and the new frame is checked from a fresh preset.
- R11: Once a frame's result has pulsed, further valid bits before the next frame_start are ignored and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe that begins a frame; carries no data bit |
| bit_valid | input | 1 | bit_in holds a stream bit this cycle |
| bit_in | input | 1 | Serial stream bit, MSB first |
| crc_ok | output | 1 | One-cycle pulse: the protected region matched the check word |
| crc_err | output | 1 | One-cycle pulse: the protected region did not match |

## Verification
Correct frames are sent in mono, plain stereo, dual channel and all four joint-stereo bounds. Because the result has to appear in exactly the cycle after the last allocation bit, each frame also tests that the region length was worked out correctly from the header. Single-bit flips are placed in the protected header, in the check word, in the allocation field and in its last bit, and each must produce an error. Flips in the sync and layer bits must still pass, which shows those bits are left out of the CRC. Further cases cover stalled valid cycles, an unprotected header, an aborted frame followed by a good one, and trailing bits after a result.

// File: rtl/mpa_crc_pkg.sv
package mpa_crc_pkg;

    localparam int CRC_W     = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;
    localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;
    localparam int SUBBANDS  = 32;
    localparam int ALLOC_W   = 4;
    localparam int HDR_HALF  = 16;
    localparam int CHK_W     = 16;
    localparam int MAX_CHANS = 2;
    localparam int ALLOC_MAX = ALLOC_W * SUBBANDS * MAX_CHANS;
    localparam int CNT_W     = $clog2(ALLOC_MAX + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FIXED,
        PH_HDRP,
        PH_CHKW,
        PH_ALLOC
    } phase_e;

    typedef enum logic [1:0] {
        CM_STEREO = 2'b00,
        CM_JOINT  = 2'b01,
        CM_DUAL   = 2'b10,
        CM_MONO   = 2'b11
    } chmode_e;

    // protected header half, packed in arrival order (first bit = MSB)
    typedef struct packed {
        logic [3:0] rate;
        logic [1:0] fs;
        logic       pad;
        logic       priv;
        chmode_e    mode;
        logic [1:0] ext;
        logic       copy;
        logic       orig;
        logic [1:0] emph;
    } hdr_prot_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic d);
        logic fb;
        logic [CRC_W-1:0] s;
        fb = c[CRC_W-1] ^ d;
        s  = {c[CRC_W-2:0], 1'b0};
        return fb ? (s ^ CRC_POLY) : s;
    endfunction

    function automatic logic [CNT_W-1:0] alloc_bits(input hdr_prot_t h);
        int chans;
        int bound;
        case (h.mode)
            CM_MONO:  begin chans = 1; bound = SUBBANDS; end
            CM_JOINT: begin chans = 2; bound = 4 * (int'(h.ext) + 1); end
            default:  begin chans = 2; bound = SUBBANDS; end
        endcase
        return CNT_W'(ALLOC_W * (chans * bound + SUBBANDS - bound));
    endfunction

endpackage

// File: rtl/mpa_crc_shift.sv
module mpa_crc_shift
    import mpa_crc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             din,
    output logic [CRC_W-1:0] crc_q,
    output logic [CRC_W-1:0] crc_nxt
);

    assign crc_nxt = crc_step(crc_q, din);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= CRC_INIT;
        end else if (shift_en) begin
            crc_q <= crc_nxt;
        end
    end

    a_r2_preset: assert property (@(posedge clk) disable iff (rst)
        clear |=> crc_q == CRC_INIT)
        else $error("crc not preset after clear");

endmodule

// File: rtl/mpa_crc_word.sv
module mpa_crc_word #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word_q
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word_q <= '0;
        end else if (shift_en) begin
            word_q <= {word_q[W-2:0], din};
        end
    end

endmodule

// File: rtl/mpa_crc_phase.sv
module mpa_crc_phase
    import mpa_crc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic bit_valid,
    input  logic bit_in,
    output logic feed_en,
    output logic chk_en,
    output logic last_bit
);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    hdr_prot_t        hdr;
    logic             take;
    logic             at_end;

    assign take     = bit_valid && !frame_start;
    assign at_end   = (cnt == '0);
    assign feed_en  = take && (phase == PH_HDRP || phase == PH_ALLOC);
    assign chk_en   = take && (phase == PH_CHKW);
    assign last_bit = take && (phase == PH_ALLOC) && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            hdr   <= '0;
        end else if (frame_start) begin
            phase <= PH_FIXED;
            cnt   <= CNT_W'(HDR_HALF - 1);
        end else if (bit_valid) begin
            case (phase)
                PH_FIXED: begin
                    if (at_end) begin
                        // last fixed bit is the protection flag: 1 = no check word
                        phase <= bit_in ? PH_IDLE : PH_HDRP;
                        cnt   <= CNT_W'(HDR_HALF - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HDRP: begin
                    hdr <= hdr_prot_t'({hdr[HDR_HALF-2:0], bit_in});
                    if (at_end) begin
                        phase <= PH_CHKW;
                        cnt   <= CNT_W'(CHK_W - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_CHKW: begin
                    if (at_end) begin
                        phase <= PH_ALLOC;
                        cnt   <= alloc_bits(hdr) - 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_ALLOC: begin
                    if (at_end) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        phase == PH_ALLOC |-> cnt < CNT_W'(ALLOC_MAX))
        else $error("allocation counter out of range");

    a_r10_restart: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> phase == PH_FIXED && cnt == CNT_W'(HDR_HALF - 1))
        else $error("frame start did not restart the sequence");

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        phase == PH_IDLE && !frame_start |=> phase == PH_IDLE)
        else $error("left idle without a frame start");

endmodule

// File: rtl/mpa_frame_crc_check.sv
module mpa_frame_crc_check
    import mpa_crc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic bit_valid,
    input  logic bit_in,
    output logic crc_ok,
    output logic crc_err
);

    logic             feed_en;
    logic             chk_en;
    logic             last_bit;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nxt;
    logic [CHK_W-1:0] chk_q;
    logic             match;

    mpa_crc_phase u_phase (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .bit_valid   (bit_valid),
        .bit_in      (bit_in),
        .feed_en     (feed_en),
        .chk_en      (chk_en),
        .last_bit    (last_bit)
    );

    mpa_crc_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .clear    (frame_start),
        .shift_en (feed_en),
        .din      (bit_in),
        .crc_q    (crc_q),
        .crc_nxt  (crc_nxt)
    );

    mpa_crc_word #(.W(CHK_W)) u_word (
        .clk      (clk),
        .rst      (rst),
        .clear    (frame_start),
        .shift_en (chk_en),
        .din      (bit_in),
        .word_q   (chk_q)
    );

    // compare against the register value that includes the last bit
    assign match = (crc_nxt == chk_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_ok  <= 1'b0;
            crc_err <= 1'b0;
        end else begin
            crc_ok  <= last_bit && match;
            crc_err <= last_bit && !match;
        end
    end

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        crc_ok |=> !crc_ok)
        else $error("pass flag longer than one cycle");

    a_r8_err_pulse: assert property (@(posedge clk) disable iff (rst)
        crc_err |=> !crc_err)
        else $error("error flag longer than one cycle");

    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(crc_ok && crc_err))
        else $error("both flags high");

    a_r10_no_flag_on_start: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !crc_ok && !crc_err)
        else $error("flag raised by aborted frame");

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
        !bit_valid && !frame_start |=> $stable(crc_q) && $stable(chk_q))
        else $error("state changed on an empty cycle");

    a_r5_chk_not_fed: assert property (@(posedge clk) disable iff (rst)
        chk_en |=> $stable(crc_q))
        else $error("check word bit entered the crc");

endmodule

// File: tb/mpa_frame_crc_check_bench.sv
module mpa_frame_crc_check_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic crc_ok;
    logic crc_err;

    always #5 clk = ~clk;

    mpa_frame_crc_check u_mpa_frame_crc_check (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .bit_valid   (bit_valid),
        .bit_in      (bit_in),
        .crc_ok      (crc_ok),
        .crc_err     (crc_err)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic fb [0:399];
    int   flen;
    logic [1:0] early;
    logic [1:0] final_f;
    logic [1:0] post;

    // {mode, ext, seed, flip (3FF = none), expect: 01 pass, 10 error}
    localparam logic [23:0] VEC [0:13] = '{
        {2'b11, 2'd0, 8'h5A, 10'h3FF, 2'b01},
        {2'b00, 2'd0, 8'h33, 10'h3FF, 2'b01},
        {2'b10, 2'd2, 8'hC7, 10'h3FF, 2'b01},
        {2'b01, 2'd0, 8'h11, 10'h3FF, 2'b01},
        {2'b01, 2'd1, 8'h22, 10'h3FF, 2'b01},
        {2'b01, 2'd2, 8'h44, 10'h3FF, 2'b01},
        {2'b01, 2'd3, 8'h88, 10'h3FF, 2'b01},
        {2'b11, 2'd0, 8'h5A, 10'd3,   2'b01},
        {2'b11, 2'd0, 8'h5A, 10'd20,  2'b10},
        {2'b00, 2'd0, 8'h33, 10'd40,  2'b10},
        {2'b01, 2'd3, 8'h88, 10'd100, 2'b10},
        {2'b01, 2'd3, 8'h88, 10'd239, 2'b10},
        {2'b11, 2'd0, 8'h5A, 10'd175, 2'b10},
        {2'b01, 2'd0, 8'h11, 10'd14,  2'b01}
    };

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: flags {err,ok} actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic int alloc_len(input logic [1:0] mode, input logic [1:0] ext);
        case (mode)
            2'b11:   return 128;
            2'b01:   return 4 * (32 + 4 * (int'(ext) + 1));
            default: return 256;
        endcase
    endfunction

    task automatic build(input logic [1:0] mode, input logic [1:0] ext,
                         input logic [7:0] seed, input logic prot);
        logic [15:0] fixed_h;
        logic [15:0] prot_h;
        logic [15:0] crc;
        logic fbk;
        int s;
        s = int'(seed);
        fixed_h = {12'hFFF, 1'b1, 2'b11, prot};
        prot_h  = {seed[7:4], seed[3:2], seed[1], seed[0], mode, ext,
                   seed[6], seed[5], seed[3:2]};
        flen = 48 + alloc_len(mode, ext);
        for (int i = 0; i < 16; i++) begin
            fb[i]      = fixed_h[15-i];
            fb[16 + i] = prot_h[15-i];
        end
        for (int i = 0; i < flen - 48; i++) begin
            fb[48 + i] = 1'(((i * 13 + s) >> 3) ^ i);
        end
        crc = 16'hFFFF;
        for (int i = 16; i < flen; i++) begin
            if (i < 32 || i >= 48) begin
                fbk = crc[15] ^ fb[i];
                crc = {crc[14:0], 1'b0};
                if (fbk) crc = crc ^ 16'h8005;
            end
        end
        for (int k = 0; k < 16; k++) fb[32 + k] = crc[15-k];
    endtask

    task automatic send(input int n, input bit stall);
        @(negedge clk);
        frame_start = 1'b1;
        bit_valid   = 1'b1;
        bit_in      = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        early = 2'b00;
        for (int i = 0; i < n; i++) begin
            bit_valid = 1'b1;
            bit_in    = fb[i];
            @(negedge clk);
            if (i < n - 1) early = early | {crc_err, crc_ok};
            if (stall && (i % 3 == 1) && i < n - 1) begin
                bit_valid = 1'b0;
                bit_in    = ~fb[i];
                @(negedge clk);
                early = early | {crc_err, crc_ok};
            end
        end
        final_f   = {crc_err, crc_ok};
        bit_valid = 1'b0;
        @(negedge clk);
        post = {crc_err, crc_ok};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 reset state", {crc_err, crc_ok}, 2'b00);

        // R1 R4 R6 R7 R8 R9 R3 R5: table walk
        foreach (VEC[v]) begin
            build(VEC[v][23:22], VEC[v][21:20], VEC[v][19:12], 1'b0);
            if (VEC[v][11:2] != 10'h3FF) fb[VEC[v][11:2]] = ~fb[VEC[v][11:2]];
            send(flen, v % 2 == 1);
            chk($sformatf("R6 vec%0d no early flag", v), early, 2'b00);
            chk($sformatf("R1 R7 R8 vec%0d result", v), final_f, VEC[v][1:0]);
            chk($sformatf("R7 vec%0d pulse ends", v), post, 2'b00);
        end

        // R3: protection bit set -> no check, no flag
        build(2'b11, 2'd0, 8'h77, 1'b1);
        send(flen, 1'b0);
        chk("R3 unprotected early", early, 2'b00);
        chk("R3 unprotected end", final_f, 2'b00);
        chk("R3 unprotected after", post, 2'b00);

        // R10: abort mid-frame, then a clean frame
        build(2'b01, 2'd1, 8'h3C, 1'b0);
        send(100, 1'b0);
        chk("R10 aborted frame silent", early | final_f | post, 2'b00);
        send(flen, 1'b0);
        chk("R10 frame after abort", final_f, 2'b01);

        // R11: trailing bits after result
        early = 2'b00;
        for (int i = 0; i < 40; i++) begin
            bit_valid = 1'b1;
            bit_in    = 1'(i ^ (i >> 2));
            @(negedge clk);
            early = early | {crc_err, crc_ok};
        end
        bit_valid = 1'b0;
        chk("R11 trailing bits ignored", early, 2'b00);

        // R2: data bit on the frame_start cycle is not taken (send drives 1 there)
        build(2'b00, 2'd0, 8'hE1, 1'b0);
        send(flen, 1'b1);
        chk("R2 start-cycle bit ignored", final_f, 2'b01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule